// File: doc/BRIEF.md
# Maskable Sixteen-Line Vectored Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines, gates them with a mask word that the processor loads through an output instruction on the I/O bus, and raises a single registered request toward the processor. When the processor acknowledges, the controller picks the highest-priority enabled line, latches that line's fixed vector address, and pulses a clear strobe back to the winning line's source.

Line 16 is not driven from outside alone. It also carries a task-ready flag that software posts with a control pulse on the I/O bus, so a program can queue deferred work and have it dispatched through the normal interrupt path. Line 15 is the slot wired to the real-time clock request. The processor's global enable and any vectors below the sixteen lines belong elsewhere.

Top module: `irqVectorUnit`

## Requirements
- R1: After reset the mask is all ones, so no line is enabled; `intReq` is 0, `lineClr` is 0, `vecAddr` is 0 and the task-ready flag is clear.
- R2: An output strobe (`ioWrite`) with `ioDev` = octal 20 and `ioFunc` = 1 loads `ioData` into the mask; `ioData[15]` is the bit for line 1 and `ioData[0]` the bit for line 16.
- R3: An output strobe to octal device 20 with function 0, or to any other device, leaves the mask unchanged.
- R4: A mask bit of 1 disables its line; a mask bit of 0 enables it.
- R5: `intReq` is the OR of all pending lines whose mask bit is 0, delayed by one register stage.
- R6: When several enabled lines are pending, the lowest line number wins (line 1, on `reqIn[15]`, is highest).
- R7: Line n has the vector address octal 063 + n (line 1 gives 064, line 15 gives 102, line 16 gives 103).
- R8: On a cycle with `intAck` high and at least one enabled pending line, the next cycle shows the winner's vector on `vecAddr` and a single-cycle one-hot pulse on that line's `lineClr` bit; `vecAddr` then holds. An acknowledge with nothing enabled and pending produces no pulse and leaves `vecAddr` unchanged.
- R9: A control pulse (`ioPulse`) with `ioDev` = octal 41 and `ioFunc` = 0 sets the task-ready flag, which requests line 16 (ORed with `reqIn[0]`); other function codes at that device have no effect.
- R10: The task-ready flag clears when an acknowledge selects line 16; if a new task pulse arrives in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 16 | Level request lines; bit 15 is line 1, bit 1 is line 15 (real-time clock), bit 0 is line 16 |
| ioWrite | input | 1 | Output-word strobe from the I/O bus |
| ioPulse | input | 1 | Control-pulse strobe from the I/O bus |
| ioDev | input | 6 | Device address on the I/O bus |
| ioFunc | input | 4 | Function code on the I/O bus |
| ioData | input | 16 | Output data word |
| intAck | input | 1 | Processor acknowledge |
| intReq | output | 1 | Registered interrupt request |
| vecAddr | output | 16 | Vector address of the last acknowledged line |
| lineClr | output | 16 | One-cycle clear pulse to the acknowledged line, same bit order as reqIn |

## Verification
The bench aims at bit ordering and polarity: a controller that numbered lines from the least significant bit, or treated a 1 as enabling, would answer a line-1 request with vector 0103 or stay silent while the mask admits it. It also drives the decode edges, where writes to the standard bank or a neighbouring device would wrongly open the mask, and an acknowledge with nothing enabled, which must neither pulse a clear nor disturb the held vector. The task flag is pushed through its clear-on-acknowledge path and through a post that lands in the acknowledge cycle, where a design letting the clear win would lose the newly queued task and drop `intReq`.

// File: rtl/irqVecPkg.sv
package irqVecPkg;

  // Strobes from bus decode/acknowledge control to the datapath
  typedef struct packed {
    logic maskLoad;
    logic taskSet;
    logic ackTake;
  } ctlStrobeT;

endpackage

// File: rtl/irqVecCtrl.sv
module irqVecCtrl
  import irqVecPkg::*;
#(
  parameter int DEV_W  = 6,
  parameter int FUNC_W = 4,
  parameter logic [DEV_W-1:0]  MASK_DEV  = 6'o20,
  parameter logic [FUNC_W-1:0] MASK_FUNC = 4'd1,
  parameter logic [DEV_W-1:0]  TASK_DEV  = 6'o41,
  parameter logic [FUNC_W-1:0] TASK_FUNC = 4'd0
) (
  input  logic              ioWrite,
  input  logic              ioPulse,
  input  logic [DEV_W-1:0]  ioDev,
  input  logic [FUNC_W-1:0] ioFunc,
  input  logic              intAck,
  output ctlStrobeT         strobe
);

  logic maskHit;
  logic taskHit;

  assign maskHit = (ioDev == MASK_DEV) && (ioFunc == MASK_FUNC);
  assign taskHit = (ioDev == TASK_DEV) && (ioFunc == TASK_FUNC);

  always_comb begin
    strobe          = '0;
    strobe.maskLoad = ioWrite && maskHit;
    strobe.taskSet  = ioPulse && taskHit;
    strobe.ackTake  = intAck;
  end

endmodule

// File: rtl/irqVecData.sv
module irqVecData
  import irqVecPkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'o64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobeT            strobe,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] ioData,
  output logic                 intReq,
  output logic [ADDR_W-1:0]    vecAddr,
  output logic [NUM_LINES-1:0] lineClr
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [IDX_W-1:0] TASK_IDX = '0;

  logic [NUM_LINES-1:0] maskReg;
  logic                 taskPend;
  logic [NUM_LINES-1:0] lineSrc;
  logic [NUM_LINES-1:0] pending;
  logic [IDX_W-1:0]     winIdx;
  logic                 winHit;
  logic [NUM_LINES-1:0] winOneHot;
  logic [ADDR_W-1:0]    winVec;
  logic                 takeWin;

  // Task flag rides on the lowest-priority line
  assign lineSrc = reqIn | {{(NUM_LINES-1){1'b0}}, taskPend};
  assign pending = lineSrc & ~maskReg;

  // Higher bit index = lower line number = higher priority
  always_comb begin
    winIdx = '0;
    winHit = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pending[i]) begin
        winIdx = IDX_W'(i);
        winHit = 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_onehot
      assign winOneHot[g] = winHit && (winIdx == IDX_W'(g));
    end
  endgenerate

  assign winVec  = VEC_BASE + ADDR_W'(NUM_LINES - 1) - ADDR_W'(winIdx);
  assign takeWin = strobe.ackTake && winHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg  <= '1;
      taskPend <= 1'b0;
      intReq   <= 1'b0;
      vecAddr  <= '0;
      lineClr  <= '0;
    end else begin
      if (strobe.maskLoad) maskReg <= ioData;
      if (strobe.taskSet) taskPend <= 1'b1;
      else if (takeWin && winIdx == TASK_IDX) taskPend <= 1'b0;
      intReq <= |pending;
      if (takeWin) vecAddr <= winVec;
      lineClr <= takeWin ? winOneHot : '0;
    end
  end

endmodule

// File: rtl/irqVectorUnit.sv
module irqVectorUnit
  import irqVecPkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 16,
  parameter int DEV_W     = 6,
  parameter int FUNC_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 ioWrite,
  input  logic                 ioPulse,
  input  logic [DEV_W-1:0]     ioDev,
  input  logic [FUNC_W-1:0]    ioFunc,
  input  logic [NUM_LINES-1:0] ioData,
  input  logic                 intAck,
  output logic                 intReq,
  output logic [ADDR_W-1:0]    vecAddr,
  output logic [NUM_LINES-1:0] lineClr
);

  ctlStrobeT strobe;

  irqVecCtrl #(.DEV_W(DEV_W), .FUNC_W(FUNC_W)) i_ctrl (
    .ioWrite(ioWrite),
    .ioPulse(ioPulse),
    .ioDev  (ioDev),
    .ioFunc (ioFunc),
    .intAck (intAck),
    .strobe (strobe)
  );

  irqVecData #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqIn  (reqIn),
    .ioData (ioData),
    .intReq (intReq),
    .vecAddr(vecAddr),
    .lineClr(lineClr)
  );

endmodule

// File: rtl/irqVectorUnitChk.sv
module irqVectorUnitChk #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intAck,
  input logic [ADDR_W-1:0]    vecAddr,
  input logic [NUM_LINES-1:0] lineClr
);

  logic [ADDR_W-1:0] clrVec;

  // Vector expected for whichever line is being cleared (line n -> octal 063 + n)
  always_comb begin
    clrVec = '0;
    for (int b = 0; b < NUM_LINES; b++) begin
      if (lineClr[b]) clrVec = ADDR_W'('o63 + (NUM_LINES - b));
    end
  end

  // R8
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lineClr));

  // R8
  clr_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|lineClr) |-> $past(intAck));

  // R8
  vec_moves_with_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vecAddr) |-> (|lineClr));

  // R7
  vec_matches_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|lineClr) |-> (vecAddr == clrVec));

endmodule

bind irqVectorUnit irqVectorUnitChk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .intAck (intAck),
  .vecAddr(vecAddr),
  .lineClr(lineClr)
);

// File: tb/test_irqVectorUnit.sv
`timescale 1ns/1ps
module test_irqVectorUnit;

  typedef struct packed {
    logic [15:0] vec;
    logic [15:0] clr;
  } expItemT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqIn = '0;
  logic        ioWrite = 1'b0;
  logic        ioPulse = 1'b0;
  logic [5:0]  ioDev = '0;
  logic [3:0]  ioFunc = '0;
  logic [15:0] ioData = '0;
  logic        intAck = 1'b0;
  logic        intReq;
  logic [15:0] vecAddr;
  logic [15:0] lineClr;

  int nRun = 0;
  int nFail = 0;
  logic [15:0] mdlMask = 16'hFFFF;
  logic        mdlTask = 1'b0;
  expItemT     expQ[$];

  always #2.5 clk = ~clk;

  irqVectorUnit i_irqVectorUnit (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ioWrite(ioWrite), .ioPulse(ioPulse),
    .ioDev(ioDev), .ioFunc(ioFunc), .ioData(ioData), .intAck(intAck),
    .intReq(intReq), .vecAddr(vecAddr), .lineClr(lineClr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ioOut(input logic [5:0] dev, input logic [3:0] fn, input logic [15:0] d);
    ioWrite = 1'b1; ioDev = dev; ioFunc = fn; ioData = d;
    if (dev == 6'o20 && fn == 4'd1) mdlMask = d;
    tick(1);
    ioWrite = 1'b0;
  endtask

  task automatic ioCtl(input logic [5:0] dev, input logic [3:0] fn);
    ioPulse = 1'b1; ioDev = dev; ioFunc = fn;
    if (dev == 6'o41 && fn == 4'd0) mdlTask = 1'b1;
    tick(1);
    ioPulse = 1'b0;
  endtask

  // Driver: computes the expected winner and pushes it to the scoreboard
  task automatic ack(input bit postTask);
    logic [15:0] p;
    expItemT it;
    p = (reqIn | {15'b0, mdlTask}) & ~mdlMask;
    for (int i = 0; i < 16; i++) begin
      if (p[i]) begin
        it.clr = 16'(1) << i;
        it.vec = 16'(8'o63 + (16 - i));
      end
    end
    if (p != 0) begin
      expQ.push_back(it);
      if (it.clr[0] && !postTask) mdlTask = 1'b0;
    end
    intAck = 1'b1;
    if (postTask) begin
      ioPulse = 1'b1; ioDev = 6'o41; ioFunc = 4'd0; mdlTask = 1'b1;
    end
    tick(1);
    intAck = 1'b0;
    ioPulse = 1'b0;
  endtask

  // Monitor: pops scoreboard entries as clear pulses appear
  always @(negedge clk) begin
    if (rstN && lineClr != 0) begin
      if (expQ.size() == 0) begin
        check("R8 unexpected clear pulse", {16'h0, lineClr}, 32'h0);
      end else begin
        expItemT e;
        e = expQ.pop_front();
        check("R8 clear line", {16'h0, lineClr}, {16'h0, e.clr});
        check("R7 vector", {16'h0, vecAddr}, {16'h0, e.vec});
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    check("R1 intReq after reset", {31'h0, intReq}, 32'h0);
    check("R1 lineClr after reset", {16'h0, lineClr}, 32'h0);
    check("R1 vecAddr after reset", {16'h0, vecAddr}, 32'h0);

    reqIn = 16'hFFFF;
    tick(2);
    check("R1 all lines masked", {31'h0, intReq}, 32'h0);

    ioOut(6'o20, 4'd0, 16'h0000);
    tick(2);
    check("R3 standard bank ignored", {31'h0, intReq}, 32'h0);
    ioOut(6'o21, 4'd1, 16'h0000);
    tick(2);
    check("R3 other device ignored", {31'h0, intReq}, 32'h0);

    ioOut(6'o20, 4'd1, 16'h7FFF);
    check("R5 one-cycle request lag", {31'h0, intReq}, 32'h0);
    tick(1);
    check("R2 R4 line 1 enabled by 0 bit", {31'h0, intReq}, 32'h1);
    ack(1'b0);
    tick(1);

    ioOut(6'o20, 4'd1, 16'h0000);
    reqIn = 16'h0003;
    tick(1);
    ack(1'b0);   // R6: line 15 over line 16
    reqIn = 16'h0120;
    tick(1);
    ack(1'b0);   // R6: line 8 over line 11
    reqIn = 16'h0000;
    tick(2);
    check("R5 no pending drops request", {31'h0, intReq}, 32'h0);
    ack(1'b0);
    check("R8 empty ack no pulse", {16'h0, lineClr}, 32'h0);
    check("R8 vector held", {16'h0, vecAddr}, 32'o73);

    ioCtl(6'o41, 4'd1);
    tick(2);
    check("R9 wrong function ignored", {31'h0, intReq}, 32'h0);
    ioCtl(6'o41, 4'd0);
    tick(1);
    check("R9 task posted", {31'h0, intReq}, 32'h1);
    ack(1'b0);
    tick(2);
    check("R10 task cleared by ack", {31'h0, intReq}, 32'h0);

    ioOut(6'o20, 4'd1, 16'h0001);
    ioCtl(6'o41, 4'd0);
    tick(2);
    check("R4 task masked", {31'h0, intReq}, 32'h0);
    ioOut(6'o20, 4'd1, 16'hFFFE);
    tick(2);
    check("R4 task unmasked", {31'h0, intReq}, 32'h1);
    ack(1'b1);
    tick(2);
    check("R10 post during ack kept", {31'h0, intReq}, 32'h1);
    ack(1'b0);
    tick(2);
    check("R10 task cleared", {31'h0, intReq}, 32'h0);
    check("R8 all expected pulses seen", expQ.size(), 32'h0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule